// File: doc/BRIEF.md
# Mesh Router XY Route Computation

This block is the route computation stage of a five-port router in a two-dimensional mesh. The router has ports toward the north, south, east and west neighbours, plus a local port toward its own processing element. A packet header arrives with destination coordinates and a code for the input port it came in on. The block subtracts the router's own coordinates from the destination, one dimension at a time. From the signs of the two offsets it picks exactly one output port.

The block always routes X before Y. A packet first travels east or west until its X coordinate matches. Only then does it travel north or south, and only when both offsets are zero is it delivered locally. Because of this fixed order, the routes are deterministic and the channel dependences never form a cycle. A header that arrives on a north or south input has already finished its X travel, so the block never turns it back into X.

The chosen port is registered as a one-hot request and held until the downstream stage acknowledges it. The header input uses a valid/ready handshake. An acknowledge and a new header can be taken in the same cycle, so one packet can be routed per clock.

Top module: `mesh_xy_route`

## Requirements
- R1: Each offset is the destination coordinate minus the router's coordinate, computed as a signed value one bit wider than a coordinate. The full span from -(K-1) to +(K-1) must be routed correctly.
- R2: A negative X offset selects the west port (request bit 0). A positive X offset selects the east port (request bit 1).
- R3: With a zero X offset, a negative Y offset selects the south port (request bit 2) and a positive Y offset selects the north port (request bit 3).
- R4: With both offsets zero, the local port is selected (request bit 4).
- R5: Whenever the X offset is nonzero, east or west is chosen whatever the Y offset is.
- R6: Input port codes are 0 local, 1 north, 2 south, 3 east, 4 west; codes 5 to 7 are routed like local. A header whose code is 1 or 2 has its X offset ignored: only north, south or local may be requested for it.
- R7: The request is registered. It appears, one-hot, on the clock edge after the header is accepted.
- R8: A request is held unchanged, and `hdr_ready` stays low, until `out_ack` is high at a clock edge. If `out_ack` and a valid header coincide, the new request replaces the old one at that edge. A header offered while the block is blocked is not taken.
- R9: While reset is active (synchronous, active low), the request is all zeros and `hdr_ready` is high from the next edge on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| my_x | input | CW | X coordinate of this router |
| my_y | input | CW | Y coordinate of this router |
| hdr_valid | input | 1 | Header present |
| hdr_ready | output | 1 | Header can be taken this cycle |
| hdr_dst_x | input | CW | Destination X coordinate |
| hdr_dst_y | input | CW | Destination Y coordinate |
| hdr_src | input | 3 | Input port the header arrived on |
| out_req | output | 5 | One-hot request {local, north, south, east, west} |
| out_ack | input | 1 | Downstream accepts the held request |

## Verification
The corner cases are the extreme offsets between opposite mesh corners and the case where both offsets are nonzero. A design without the extra sign bit would read a distance of 7 as negative and send the packet the wrong way. A design that corrected Y first would fail the cases where both offsets are nonzero. Headers arriving from the north or south carry a deliberate X mismatch; a design that allowed a Y-to-X turn would request east or west for them. The bench also stalls the acknowledge and offers a competing header while blocked, which catches a request that changes or is overwritten while held. A simultaneous acknowledge and new header shows whether a design loses a cycle or drops a packet.

// File: rtl/mesh_route_pkg.sv
// Shared constants for the mesh route stage: output request bit positions
// and input port codes. Assumes five router ports.
package mesh_route_pkg;
    localparam int NUM_PORTS = 5;
    localparam int BIT_WEST  = 0;
    localparam int BIT_EAST  = 1;
    localparam int BIT_SOUTH = 2;
    localparam int BIT_NORTH = 3;
    localparam int BIT_LOCAL = 4;

    typedef enum logic [2:0] {
        SRC_LOCAL = 3'd0,
        SRC_NORTH = 3'd1,
        SRC_SOUTH = 3'd2,
        SRC_EAST  = 3'd3,
        SRC_WEST  = 3'd4
    } src_port_e;
endpackage

// File: rtl/mesh_offset_calc.sv
// Signed per-dimension offset: destination minus own coordinate.
// Assumes unsigned coordinates of CW bits; result has one extra sign bit
// so that the whole range -(2^CW-1)..+(2^CW-1) is representable.
module mesh_offset_calc #(
    parameter int CW = 3
) (
    input  logic [CW-1:0]      dst,
    input  logic [CW-1:0]      here,
    output logic signed [CW:0] offset
);
    // Zero-extend both operands, then subtract as signed values.
    always_comb begin
        offset = $signed({1'b0, dst}) - $signed({1'b0, here});
    end
endmodule

// File: rtl/mesh_port_select.sv
// Chooses one output port from the two offsets using X-then-Y order.
// Assumes y_only is set for headers that arrived from a north/south input,
// which must never turn back into the X dimension.
module mesh_port_select
    import mesh_route_pkg::*;
#(
    parameter int OW = 4
) (
    input  logic signed [OW-1:0] dx,
    input  logic signed [OW-1:0] dy,
    input  logic                 y_only,
    output logic [NUM_PORTS-1:0] port
);
    logic x_left, x_right;

    // X is considered only when a turn into X is allowed.
    always_comb begin
        x_left  = !y_only && (dx < 0);
        x_right = !y_only && (dx > 0);
    end

    // Priority: X correction, then Y correction, then local delivery.
    always_comb begin
        port = '0;
        if (x_left)       port[BIT_WEST]  = 1'b1;
        else if (x_right) port[BIT_EAST]  = 1'b1;
        else if (dy < 0)  port[BIT_SOUTH] = 1'b1;
        else if (dy > 0)  port[BIT_NORTH] = 1'b1;
        else              port[BIT_LOCAL] = 1'b1;
    end
endmodule

// File: rtl/mesh_req_hold.sv
// Holds the registered one-hot request until it is acknowledged.
// Assumes load is only raised when the stage can accept (ready high).
module mesh_req_hold
    import mesh_route_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 load,
    input  logic [NUM_PORTS-1:0] next_req,
    input  logic                 ack,
    output logic [NUM_PORTS-1:0] req,
    output logic                 ready
);
    logic busy;

    // A nonzero request marks the stage as occupied.
    always_comb busy = |req;

    // The stage can take a header when empty or when it is being drained.
    always_comb ready = !busy || ack;

    // Load a new request, clear on acknowledge, otherwise hold.
    always_ff @(posedge clk) begin
        if (!rst_n)     req <= '0;
        else if (load)  req <= next_req;
        else if (ack)   req <= '0;
    end

    AST_REQ_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(req));                                            // R7
    AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !ack) |=> $stable(req));                          // R8
    AST_BLOCKED_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !ack) |-> !ready);                                // R8
endmodule

// File: rtl/mesh_xy_route.sv
// Route computation stage of a five-port 2D mesh router using
// dimension-order (X then Y) routing. Assumes K nodes per dimension,
// unsigned coordinates, and that headers from north/south inputs have
// finished their X travel.
module mesh_xy_route
    import mesh_route_pkg::*;
#(
    parameter int K  = 8,
    parameter int CW = (K > 1) ? $clog2(K) : 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [CW-1:0]        my_x,
    input  logic [CW-1:0]        my_y,
    input  logic                 hdr_valid,
    output logic                 hdr_ready,
    input  logic [CW-1:0]        hdr_dst_x,
    input  logic [CW-1:0]        hdr_dst_y,
    input  logic [2:0]           hdr_src,
    output logic [NUM_PORTS-1:0] out_req,
    input  logic                 out_ack
);
    localparam int OW   = CW + 1;
    localparam int DIMS = 2;

    logic [DIMS-1:0][CW-1:0] dst_c, own_c;
    logic signed [OW-1:0]    off [DIMS];
    logic                    y_only;
    logic                    take;
    logic [NUM_PORTS-1:0]    pick;

    // Gather coordinates per dimension: index 0 is X, index 1 is Y.
    always_comb begin
        dst_c[0] = hdr_dst_x;
        dst_c[1] = hdr_dst_y;
        own_c[0] = my_x;
        own_c[1] = my_y;
    end

    // One offset calculator per dimension.
    for (genvar d = 0; d < DIMS; d++) begin : g_dim
        mesh_offset_calc #(.CW(CW)) u_off (
            .dst    (dst_c[d]),
            .here   (own_c[d]),
            .offset (off[d])
        );
    end

    // Headers from a Y-direction input may not turn into X.
    always_comb y_only = (hdr_src == SRC_NORTH) || (hdr_src == SRC_SOUTH);

    // Header handshake completes when both sides agree.
    always_comb take = hdr_valid && hdr_ready;

    mesh_port_select #(.OW(OW)) u_sel (
        .dx     (off[0]),
        .dy     (off[1]),
        .y_only (y_only),
        .port   (pick)
    );

    mesh_req_hold u_hold (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (take),
        .next_req (pick),
        .ack      (out_ack),
        .req      (out_req),
        .ready    (hdr_ready)
    );

    AST_NO_Y_TO_X: assert property (@(posedge clk) disable iff (!rst_n)
        (take && (hdr_src == SRC_NORTH || hdr_src == SRC_SOUTH))
        |=> !(out_req[BIT_EAST] || out_req[BIT_WEST]));            // R6
    AST_ACCEPT_GIVES_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        take |=> (out_req != '0));                                 // R7
    AST_X_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        (take && !y_only && hdr_dst_x != my_x)
        |=> (out_req[BIT_EAST] || out_req[BIT_WEST]));             // R5
endmodule

// File: tb/mesh_xy_route_test.sv
module mesh_xy_route_test;
    localparam int K  = 8;
    localparam int CW = 3;
    localparam int NV = 15;
    localparam logic [4:0] L = 5'b10000, N = 5'b01000, S = 5'b00100,
                           E = 5'b00010, W = 5'b00001;

    // {req tag, my_x, my_y, dst_x, dst_y, src, expected request}
    localparam logic [23:0] VEC [NV] = '{
        {4'd2, 3'd3, 3'd3, 3'd1, 3'd3, 3'd0, W},  // R2 west
        {4'd2, 3'd3, 3'd3, 3'd6, 3'd3, 3'd0, E},  // R2 east
        {4'd3, 3'd3, 3'd3, 3'd3, 3'd0, 3'd0, S},  // R3 south
        {4'd3, 3'd3, 3'd3, 3'd3, 3'd7, 3'd0, N},  // R3 north
        {4'd4, 3'd3, 3'd3, 3'd3, 3'd3, 3'd0, L},  // R4 local
        {4'd5, 3'd3, 3'd3, 3'd5, 3'd0, 3'd0, E},  // R5 X before Y
        {4'd5, 3'd3, 3'd3, 3'd0, 3'd7, 3'd3, W},  // R5 X before Y
        {4'd1, 3'd0, 3'd0, 3'd7, 3'd7, 3'd0, E},  // R1 +7
        {4'd1, 3'd7, 3'd7, 3'd0, 3'd0, 3'd0, W},  // R1 -7
        {4'd1, 3'd0, 3'd7, 3'd0, 3'd0, 3'd0, S},  // R1 -7 in Y
        {4'd6, 3'd3, 3'd3, 3'd5, 3'd6, 3'd1, N},  // R6 from north
        {4'd6, 3'd3, 3'd3, 3'd0, 3'd1, 3'd2, S},  // R6 from south
        {4'd6, 3'd3, 3'd3, 3'd6, 3'd3, 3'd1, L},  // R6 X ignored
        {4'd6, 3'd3, 3'd3, 3'd6, 3'd3, 3'd3, E},  // R6 from east
        {4'd6, 3'd4, 3'd2, 3'd1, 3'd5, 3'd7, W}   // R6 code 7 as local
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [CW-1:0] my_x = '0, my_y = '0, hdr_dst_x = '0, hdr_dst_y = '0;
    logic hdr_valid = 1'b0, out_ack = 1'b0;
    logic [2:0] hdr_src = '0;
    logic hdr_ready;
    logic [4:0] out_req;
    int n_run = 0, n_fail = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    mesh_xy_route #(.K(K)) uut (
        .clk(clk), .rst_n(rst_n), .my_x(my_x), .my_y(my_y),
        .hdr_valid(hdr_valid), .hdr_ready(hdr_ready),
        .hdr_dst_x(hdr_dst_x), .hdr_dst_y(hdr_dst_y), .hdr_src(hdr_src),
        .out_req(out_req), .out_ack(out_ack)
    );

    task automatic chk(input string tag, input logic [4:0] act, input logic [4:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %b expected %b", tag, act, exp);
        end
    endtask

    task automatic drive(input logic [2:0] mx, my, dx, dy, src);
        my_x = mx; my_y = my; hdr_dst_x = dx; hdr_dst_y = dy; hdr_src = src;
        hdr_valid = 1'b1;
    endtask

    initial begin
        // Reset state (R9)
        repeat (2) @(negedge clk);
        chk("R9 req in reset", out_req, 5'b0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R9 ready after reset", {4'b0, hdr_ready}, 5'b1);

        // Vector table walk (R1..R7)
        for (int i = 0; i < NV; i++) begin
            drive(VEC[i][19:17], VEC[i][16:14], VEC[i][13:11], VEC[i][10:8], VEC[i][7:5]);
            @(negedge clk);
            hdr_valid = 1'b0;
            chk($sformatf("R%0d vector %0d (R7 registered)", VEC[i][23:20], i), out_req, VEC[i][4:0]);
            out_ack = 1'b1;
            @(negedge clk);
            out_ack = 1'b0;
            chk($sformatf("R8 cleared after ack, vector %0d", i), out_req, 5'b0);
        end

        // Hold without ack, competing header offered while blocked (R8)
        drive(3'd2, 3'd2, 3'd0, 3'd2, 3'd0);
        @(negedge clk);
        drive(3'd2, 3'd2, 3'd5, 3'd2, 3'd0);
        repeat (3) @(negedge clk);
        chk("R8 held request", out_req, W);
        chk("R8 ready low while held", {4'b0, hdr_ready}, 5'b0);
        hdr_valid = 1'b0;
        out_ack = 1'b1;
        @(negedge clk);
        out_ack = 1'b0;
        chk("R8 blocked header not taken", out_req, 5'b0);

        // Back-to-back: ack and new header in the same cycle (R8)
        drive(3'd2, 3'd2, 3'd2, 3'd6, 3'd0);
        @(negedge clk);
        drive(3'd2, 3'd2, 3'd2, 3'd2, 3'd0);
        out_ack = 1'b1;
        @(negedge clk);
        hdr_valid = 1'b0;
        out_ack = 1'b0;
        chk("R8 replace on ack", out_req, L);

        // Reset while holding (R9)
        rst_n = 1'b0;
        @(negedge clk);
        chk("R9 reset clears held request", out_req, 5'b0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R9 ready after mid reset", {4'b0, hdr_ready}, 5'b1);
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (5000) @(posedge clk);
                n_run++;
                n_fail++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule